// File: doc/BRIEF.md
# Host register bridge to FIFOs

This block links a small synchronous host register port to two byte-wide FIFOs that face application logic. Bytes the host writes land in a download FIFO, which the application drains through a first-word-fall-through interface: the head byte is always present on the data output, and a one-cycle remove strobe advances it. Bytes the application adds go into an upload FIFO, which the host drains by reading a data register.

Beyond the data register, the host sees a packed status word holding the empty and full flags of both FIFOs, one occupancy register per FIFO, a command that empties both FIFOs at once, and a register whose low bit drives a break line toward the application. Host software polls the status and level registers and avoids overrunning or underrunning either FIFO. Both sides share one clock, and the design uses an active-high synchronous reset. DEPTH must be a power of two.

Top module: `hostfifo_bridge`

## Requirements
- R1: A host write (host_wr high) to address 0 pushes host_wdata into the download FIFO at that clock edge. The byte then appears on app_rx_data if the FIFO was empty, and app_rx_level rises by one.
- R2: While the download FIFO is not empty, app_rx_data shows its oldest byte. A cycle with app_rx_take high advances the head at the next edge, and app_rx_empty, app_rx_full and app_rx_level update at that same edge.
- R3: A cycle with app_tx_put high stores app_tx_data in the upload FIFO at the next edge, and app_tx_empty, app_tx_full and app_tx_level update at that edge.
- R4: A host read (host_rd high) of address 0 pops the upload FIFO. host_rdata shows the popped head byte from the edge that accepts the read until the next read. A read of address 0 while the upload FIFO is empty returns 0.
- R5: A host read of address 1 returns a status word with bit 0 download empty, bit 1 download full, bit 2 upload empty and bit 3 upload full. All other bits read 0.
- R6: A host read of address 2 returns the download level and a read of address 3 returns the upload level, zero-extended. Reads of addresses 5 to 7 return 0.
- R7: A host write to address 1 empties both FIFOs at that edge, whatever the data. This takes priority over a push or pop in the same cycle.
- R8: A host write to address 4 sets app_break to bit 0 of host_wdata at that edge. app_break holds that value until the next such write.
- R9: A push to a full FIFO and a pop from an empty FIFO are ignored and leave the contents and level unchanged. A push and a pop on the same FIFO in the same cycle leave its level unchanged.
- R10: Each FIFO holds DEPTH (default 16) bytes, keeps first-in first-out order across pointer wrap-around, and reports full at a level of DEPTH.
- R11: After reset, both FIFOs are empty, both levels are 0, app_break is 0 and host_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | AW (3) | Host register address |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | DW (8) | Host write data |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | DW (8) | Registered host read data |
| app_rx_data | output | DW (8) | Download FIFO head byte |
| app_rx_take | input | 1 | Remove the download head byte |
| app_rx_empty | output | 1 | Download FIFO empty |
| app_rx_full | output | 1 | Download FIFO full |
| app_rx_level | output | LW (5) | Download FIFO occupancy |
| app_tx_data | input | DW (8) | Byte to add to the upload FIFO |
| app_tx_put | input | 1 | Add app_tx_data to the upload FIFO |
| app_tx_empty | output | 1 | Upload FIFO empty |
| app_tx_full | output | 1 | Upload FIFO full |
| app_tx_level | output | LW (5) | Upload FIFO occupancy |
| app_break | output | 1 | Break indication to the application |

## Verification
Every result in this block is due exactly one rising edge after its strobe. This covers a push, a pop, a clear, a break write, and the registered host read data, which reflects the state before that edge. The bench raises each strobe just after a falling edge and lowers it at the next falling edge. It samples at that same falling edge, which lies half a period after the edge that did the work, so every check reads the post-edge value and no check waits an extra cycle. The bench sweeps every fill level from empty to full and drains back, using pointer start offsets of 0 and 5, so that wrap-around is covered.

// File: rtl/hostfifo_bridge.sv
module hostfifo_bridge #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [AW-1:0]                host_addr,
  input  logic                         host_wr,
  input  logic [DW-1:0]                host_wdata,
  input  logic                         host_rd,
  output logic [DW-1:0]                host_rdata,
  output logic [DW-1:0]                app_rx_data,
  input  logic                         app_rx_take,
  output logic                         app_rx_empty,
  output logic                         app_rx_full,
  output logic [$clog2(DEPTH+1)-1:0]   app_rx_level,
  input  logic [DW-1:0]                app_tx_data,
  input  logic                         app_tx_put,
  output logic                         app_tx_empty,
  output logic                         app_tx_full,
  output logic [$clog2(DEPTH+1)-1:0]   app_tx_level,
  output logic                         app_break
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);

  logic [DW-1:0] dn_mem [DEPTH];
  logic [DW-1:0] up_mem [DEPTH];
  logic [PW-1:0] dn_wp, dn_rp, up_wp, up_rp;
  logic [LW-1:0] dn_lvl, up_lvl;

  wire sel0 = host_addr == AW'(0);
  wire sel1 = host_addr == AW'(1);
  wire sel4 = host_addr == AW'(4);
  wire clr     = host_wr && sel1;
  wire dn_push = host_wr && sel0 && !app_rx_full;
  wire dn_pop  = app_rx_take && !app_rx_empty;
  wire up_push = app_tx_put && !app_tx_full;
  wire up_pop  = host_rd && sel0 && !app_tx_empty;

  assign app_rx_empty = dn_lvl == LW'(0);
  assign app_rx_full  = dn_lvl == LW'(DEPTH);
  assign app_tx_empty = up_lvl == LW'(0);
  assign app_tx_full  = up_lvl == LW'(DEPTH);
  assign app_rx_level = dn_lvl;
  assign app_tx_level = up_lvl;
  assign app_rx_data  = dn_mem[dn_rp];

  always_ff @(posedge clk) begin
    if (dn_push) dn_mem[dn_wp] <= host_wdata;
    if (up_push) up_mem[up_wp] <= app_tx_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      dn_wp <= '0; dn_rp <= '0; dn_lvl <= '0;
      up_wp <= '0; up_rp <= '0; up_lvl <= '0;
    end else begin
      if (dn_push) dn_wp <= dn_wp + PW'(1);
      if (dn_pop)  dn_rp <= dn_rp + PW'(1);
      if (up_push) up_wp <= up_wp + PW'(1);
      if (up_pop)  up_rp <= up_rp + PW'(1);
      dn_lvl <= dn_lvl + LW'(dn_push) - LW'(dn_pop);
      up_lvl <= up_lvl + LW'(up_push) - LW'(up_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) app_break <= 1'b0;
    else if (host_wr && sel4) app_break <= host_wdata[0];
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else if (host_rd) begin
      case (host_addr)
        AW'(0):  host_rdata <= app_tx_empty ? '0 : up_mem[up_rp];
        AW'(1):  host_rdata <= DW'({app_tx_full, app_tx_empty, app_rx_full, app_rx_empty});
        AW'(2):  host_rdata <= DW'(dn_lvl);
        AW'(3):  host_rdata <= DW'(up_lvl);
        default: host_rdata <= '0;
      endcase
    end
  end

  assert_clear_empties_R7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (app_rx_empty && app_tx_empty && app_rx_level == '0 && app_tx_level == '0));

  assert_full_push_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (app_rx_full && host_wr && sel0 && !app_rx_take) |=> (app_rx_full && $stable(app_rx_data)));

  assert_empty_read_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (host_rd && sel0 && app_tx_empty) |=> (host_rdata == '0));

  assert_break_follows_R8: assert property (@(posedge clk) disable iff (rst)
    (host_wr && sel4) |=> (app_break == $past(host_wdata[0])));

  assert_level_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!clr && !host_wr && !app_tx_put && !host_rd) |=> ($stable(app_tx_level) && (app_rx_level <= $past(app_rx_level))));

  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(app_rx_empty && app_rx_full) && !(app_tx_empty && app_tx_full));
endmodule

// File: tb/hostfifo_bridge_bench.sv
module hostfifo_bridge_bench;
  localparam int DEPTH = 16;
  logic clk = 0, rst = 1;
  logic [2:0] host_addr = 0;
  logic host_wr = 0, host_rd = 0, app_rx_take = 0, app_tx_put = 0;
  logic [7:0] host_wdata = 0, app_tx_data = 0;
  logic [7:0] host_rdata, app_rx_data;
  logic app_rx_empty, app_rx_full, app_tx_empty, app_tx_full, app_break;
  logic [4:0] app_rx_level, app_tx_level;
  int compared = 0, mismatched = 0;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  hostfifo_bridge u_hostfifo_bridge (.*);

  task automatic check(string tag, int got, int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic hwrite(int a, int d);
    @(negedge clk); host_addr = 3'(a); host_wdata = 8'(d); host_wr = 1;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic hread(int a, output logic [7:0] r);
    @(negedge clk); host_addr = 3'(a); host_rd = 1;
    @(negedge clk); host_rd = 0; r = host_rdata;
  endtask

  task automatic take();
    @(negedge clk); app_rx_take = 1;
    @(negedge clk); app_rx_take = 0;
  endtask

  task automatic put(int d);
    @(negedge clk); app_tx_data = 8'(d); app_tx_put = 1;
    @(negedge clk); app_tx_put = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    mismatched++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R11 rx_empty", app_rx_empty, 1);
    check("R11 tx_empty", app_tx_empty, 1);
    check("R11 rx_level", app_rx_level, 0);
    check("R11 tx_level", app_tx_level, 0);
    check("R11 break", app_break, 0);
    check("R11 rdata", host_rdata, 0);
    hread(1, v); check("R5 status reset", v, 8'h5);

    for (int off = 0; off < 6; off += 5) begin
      for (int i = 0; i < off; i++) begin hwrite(0, 99); take(); put(98); hread(0, v); end
      for (int i = 0; i < DEPTH; i++) begin
        hwrite(0, (i * 7 + 3 + off) & 255);
        check("R1 rx_level", app_rx_level, i + 1);
        check("R10 rx_full", app_rx_full, (i == DEPTH - 1) ? 1 : 0);
        hread(2, v); check("R6 dn level reg", v, i + 1);
        put((i * 13 + 5 + off) & 255);
        check("R3 tx_level", app_tx_level, i + 1);
        check("R3 tx_empty", app_tx_empty, 0);
        hread(3, v); check("R6 up level reg", v, i + 1);
      end
      hread(1, v); check("R5 status both full", v, 8'hA);
      hwrite(0, 200);
      check("R9 push full ignored", app_rx_level, DEPTH);
      put(201);
      check("R9 put full ignored", app_tx_level, DEPTH);
      for (int i = 0; i < DEPTH; i++) begin
        check("R2 rx head", app_rx_data, (i * 7 + 3 + off) & 255);
        take();
        check("R2 rx_level", app_rx_level, DEPTH - 1 - i);
        check("R2 rx_empty", app_rx_empty, (i == DEPTH - 1) ? 1 : 0);
        hread(0, v);
        check("R4 up pop data", v, (i * 13 + 5 + off) & 255);
        check("R4 tx_level", app_tx_level, DEPTH - 1 - i);
      end
      take();
      check("R9 take empty ignored", app_rx_level, 0);
      hread(0, v); check("R4 empty read zero", v, 0);
      check("R9 pop empty level", app_tx_level, 0);
      hread(1, v); check("R5 status empty", v, 8'h5);
    end

    for (int a = 5; a < 8; a++) begin hread(a, v); check("R6 unused addr", v, 0); end

    for (int i = 0; i < 3; i++) begin hwrite(0, 40 + i); put(50 + i); end
    @(negedge clk); host_addr = 0; host_wdata = 77; host_wr = 1; app_rx_take = 1;
    @(negedge clk); host_wr = 0; app_rx_take = 0;
    check("R9 push+pop level", app_rx_level, 3);
    check("R9 push+pop head", app_rx_data, 41);
    hread(1, v); check("R5 status mixed", v, 8'h0);
    hwrite(1, 8'hFF);
    check("R7 clear rx", app_rx_level, 0);
    check("R7 clear tx", app_tx_level, 0);
    hread(1, v); check("R7 status after clear", v, 8'h5);
    hread(0, v); check("R7 read after clear", v, 0);

    hwrite(4, 8'h03); check("R8 break set", app_break, 1);
    hwrite(0, 9);     check("R8 break held", app_break, 1);
    hwrite(4, 8'h02); check("R8 break clear", app_break, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule